// File: doc/BRIEF.md
# Exception entry and return controller

This block sits beside a simple CPU core and decides, each clock, whether the core must leave its normal instruction flow. It looks at a general exception strobe from the pipeline, a return-from-exception strobe, a nonmaskable interrupt pulse, a debug-interface interrupt line and a 4-bit encoded external interrupt level. It weighs these against the block bit of the status register that the core presents. When it accepts an event, it saves the program counter and status register, records a 12-bit event code, and one cycle later presents a redirect with a branch target and a new status value that has the block bit set. On a return it presents the saved program counter as the target and the saved status as the new status.

The core must apply `sr_o` to its status register when it sees `redirect_o`, so that `sr_i` shows the new value by the following edge. The cycle in which a redirect is presented is treated as blocked. A general exception that arrives while the core is blocked is not nested. It restarts the core at the fixed reset address with the status reset value and a cleared vector base. Interrupts that arrive while blocked are only held off.

Top module: `exc_ctrl`

## Requirements
- R1: External level n on `irl_i`, for n from 0 to 14, is accepted with event code 0x200 + 0x20·n and branch target vector base + 0x600. The value 4'b1111 means no request.
- R2: The nonmaskable interrupt records code 0x1C0 and the debug interrupt records code 0x5E0. The event register never holds 0x120, 0x140 or 0x3E0.
- R3: On acceptance of a general exception with the block bit (bit 28 of `sr_i`) at 0, one edge loads `spc_o` with `pc_i`, `ssr_o` with `sr_i` and `evt_o` with `exc_code_i`. In the next cycle `redirect_o` is high, `target_o` is vector base + 0x100, and `sr_o` is `sr_i` with bit 28 set. Interrupt acceptance saves and sets bit 28 in the same way.
- R4: When several events fall in one cycle, the precedence is general exception, then return, then nonmaskable, then debug, then external level. Lower-ranked interrupts stay unaccepted.
- R5: While bit 28 of `sr_i` is 1, or during a cycle in which `redirect_o` is high, no interrupt is accepted and no redirect follows. A debug or level request that is still present once bit 28 is cleared is then accepted.
- R6: A one-cycle `nmi_i` pulse that arrives while blocked is remembered. It is accepted once, after blocking ends.
- R7: A general exception while blocked gives a redirect to 0xA0000000 with `cpu_rst_o` high and `sr_o` = 0x700000F0. It clears the vector base and the event register to 0 and leaves `spc_o` and `ssr_o` unchanged.
- R8: `rte_i`, regardless of bit 28, gives a redirect to the saved PC with `sr_o` equal to the saved SR. The saved registers and the event register are unchanged.
- R9: After software clears bit 28, a new acceptance overwrites `spc_o` and `ssr_o`.
- R10: After reset, all outputs are 0 and the vector base is 0. `vbr_we_i` loads `vbr_d_i` into the vector base at the edge, and the new base is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irl_i | input | 4 | Encoded external interrupt level, 4'b1111 = none |
| nmi_i | input | 1 | Nonmaskable interrupt pulse |
| dbg_irq_i | input | 1 | Debug-interface interrupt request (level) |
| gen_exc_i | input | 1 | General exception strobe from the pipeline |
| exc_code_i | input | 12 | Event code of the general exception |
| rte_i | input | 1 | Return-from-exception strobe |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status register, bit 28 = block bit |
| vbr_we_i | input | 1 | Vector base write enable |
| vbr_d_i | input | 32 | Vector base write data |
| redirect_o | output | 1 | One-cycle redirect request |
| target_o | output | 32 | Branch target, valid with redirect_o |
| sr_o | output | 32 | New status value, valid with redirect_o |
| cpu_rst_o | output | 1 | Redirect is a reset-like restart |
| spc_o | output | 32 | Saved program counter |
| ssr_o | output | 32 | Saved status register |
| evt_o | output | 12 | Event code register |

## Verification
The hardest case to reach is a nonmaskable pulse or a debug request that lands while the core is blocked. It must be seen to cause no redirect for several cycles and then exactly one acceptance after software clears the block bit. The same applies when that pending event collides with a general exception or a return in the same cycle. The bench acts as the core: it feeds `sr_o` back into `sr_i` and clears bit 28 at chosen points. It parks the interrupt in the blocked window, keeps the debug line high across it, and releases the block only after idle cycles have been checked for silence. A reference model inside the bench predicts every cycle's redirect, target, status and saved registers.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W = 12;
  localparam int LVL_W  = 4;

  typedef enum logic [2:0] {
    K_NONE,
    K_RESET,
    K_GEXC,
    K_RTE,
    K_NMI,
    K_DBG,
    K_IRL
  } kind_e;

  localparam logic [CODE_W-1:0] CODE_NMI  = 12'h1C0;
  localparam logic [CODE_W-1:0] CODE_DBG  = 12'h5E0;
  localparam logic [CODE_W-1:0] CODE_IRL0 = 12'h200;
  localparam logic [LVL_W-1:0]  LVL_NONE  = '1;

  // level n -> 0x200 + 32*n
  function automatic logic [CODE_W-1:0] irl_code(input logic [LVL_W-1:0] lvl);
    return CODE_IRL0 + {{(CODE_W-LVL_W-5){1'b0}}, lvl, 5'b0};
  endfunction
endpackage

// File: rtl/exc_nmi.sv
module exc_nmi (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (take_i)  pend_q <= 1'b0;
    else if (nmi_i)   pend_q <= 1'b1;
  end

  assign pend_o = pend_q | nmi_i;

  // R6
  nmi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !take_i) |=> pend_o);

  // R6
  nmi_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !pend_q);
endmodule

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_exc_i,
  input  logic              rte_i,
  input  logic              blocked_i,
  input  logic              nmi_pend_i,
  input  logic              dbg_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [CODE_W-1:0] gexc_code_i,
  output kind_e             kind_o,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    kind_o = K_NONE;
    code_o = gexc_code_i;
    if (gen_exc_i) begin
      kind_o = blocked_i ? K_RESET : K_GEXC;
    end else if (rte_i) begin
      kind_o = K_RTE;
    end else if (!blocked_i) begin
      if (nmi_pend_i) begin
        kind_o = K_NMI;
        code_o = CODE_NMI;
      end else if (dbg_i) begin
        kind_o = K_DBG;
        code_o = CODE_DBG;
      end else if (lvl_i != LVL_NONE) begin
        kind_o = K_IRL;
        code_o = irl_code(lvl_i);
      end
    end
  end

  // R1
  irl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == K_IRL) |-> (code_o >= 12'h200 && code_o <= 12'h3C0 && code_o[4:0] == 5'd0));

  // R4
  nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_i && !blocked_i && !gen_exc_i && !rte_i) |-> (kind_o == K_NMI));
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic              clr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              vbr_we_i,
  input  logic [XLEN-1:0]   vbr_d_i,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [CODE_W-1:0] evt_o,
  output logic [XLEN-1:0]   vbr_o
);
  logic [XLEN-1:0]   spc_q, ssr_q, vbr_q;
  logic [CODE_W-1:0] evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spc_q <= '0;
      ssr_q <= '0;
      evt_q <= '0;
      vbr_q <= '0;
    end else if (clr_i) begin
      // reset-like restart: core-side state only
      evt_q <= '0;
      vbr_q <= '0;
    end else begin
      if (save_i) begin
        spc_q <= pc_i;
        ssr_q <= sr_i;
        evt_q <= code_i;
      end
      if (vbr_we_i) vbr_q <= vbr_d_i;
    end
  end

  assign spc_o = spc_q;
  assign ssr_o = ssr_q;
  assign evt_o = evt_q;
  assign vbr_o = vbr_q;

  // R2
  no_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q != 12'h120) && (evt_q != 12'h140) && (evt_q != 12'h3E0));

  // R3
  save_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !clr_i) |=> (spc_q == $past(pc_i) && ssr_q == $past(sr_i)));

  // R7
  vbr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vbr_q == '0 && evt_q == '0));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              BL_BIT    = 28,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000,
  parameter logic [XLEN-1:0] RESET_SR  = 32'h7000_00F0,
  parameter logic [XLEN-1:0] GEXC_OFS  = 32'h0000_0100,
  parameter logic [XLEN-1:0] IRQ_OFS   = 32'h0000_0600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  irl_i,
  input  logic              nmi_i,
  input  logic              dbg_irq_i,
  input  logic              gen_exc_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              rte_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic              vbr_we_i,
  input  logic [XLEN-1:0]   vbr_d_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic [XLEN-1:0]   sr_o,
  output logic              cpu_rst_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [CODE_W-1:0] evt_o
);
  localparam logic [XLEN-1:0] BL_MASK = XLEN'(1) << BL_BIT;

  logic              redirect_q, cpu_rst_q;
  logic [XLEN-1:0]   target_q, sr_q, target_d, sr_d;
  logic              blocked, nmi_pend, save, clr;
  kind_e             kind;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   spc, ssr, vbr;

  // redirect cycle counts as blocked: core has not yet applied sr_o
  assign blocked = sr_i[BL_BIT] | redirect_q;

  exc_nmi u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .take_i (kind == K_NMI),
    .pend_o (nmi_pend)
  );

  exc_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gen_exc_i   (gen_exc_i),
    .rte_i       (rte_i),
    .blocked_i   (blocked),
    .nmi_pend_i  (nmi_pend),
    .dbg_i       (dbg_irq_i),
    .lvl_i       (irl_i),
    .gexc_code_i (exc_code_i),
    .kind_o      (kind),
    .code_o      (code)
  );

  assign save = (kind == K_GEXC) || (kind == K_NMI) || (kind == K_DBG) || (kind == K_IRL);
  assign clr  = (kind == K_RESET);

  exc_regs #(.XLEN(XLEN)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .save_i   (save),
    .clr_i    (clr),
    .pc_i     (pc_i),
    .sr_i     (sr_i),
    .code_i   (code),
    .vbr_we_i (vbr_we_i),
    .vbr_d_i  (vbr_d_i),
    .spc_o    (spc),
    .ssr_o    (ssr),
    .evt_o    (evt_o),
    .vbr_o    (vbr)
  );

  always_comb begin
    target_d = '0;
    sr_d     = '0;
    unique case (kind)
      K_RESET: begin
        target_d = RESET_VEC;
        sr_d     = RESET_SR;
      end
      K_GEXC: begin
        target_d = vbr + GEXC_OFS;
        sr_d     = sr_i | BL_MASK;
      end
      K_RTE: begin
        target_d = spc;
        sr_d     = ssr;
      end
      K_NMI, K_DBG, K_IRL: begin
        target_d = vbr + IRQ_OFS;
        sr_d     = sr_i | BL_MASK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q <= 1'b0;
      cpu_rst_q  <= 1'b0;
      target_q   <= '0;
      sr_q       <= '0;
    end else begin
      redirect_q <= (kind != K_NONE);
      cpu_rst_q  <= clr;
      target_q   <= target_d;
      sr_q       <= sr_d;
    end
  end

  assign redirect_o = redirect_q;
  assign cpu_rst_o  = cpu_rst_q;
  assign target_o   = target_q;
  assign sr_o       = sr_q;
  assign spc_o      = spc;
  assign ssr_o      = ssr;

  // R5
  blocked_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_exc_i && !rte_i && sr_i[BL_BIT]) |=> !redirect_o);

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_exc_i && sr_i[BL_BIT]) |=> (cpu_rst_o && target_o == RESET_VEC && sr_o == RESET_SR));

  // R8
  rte_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rte_i && !gen_exc_i) |=> (redirect_o && target_o == $past(spc_o) && sr_o == $past(ssr_o)));

  // R3
  bl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_i[BL_BIT] && !redirect_o && !rte_i && (gen_exc_i || dbg_irq_i)) |=> (redirect_o && sr_o[BL_BIT]));
endmodule

// File: tb/exc_ctrl_tb.sv
`timescale 1ns/1ps
module exc_ctrl_tb;
  localparam int BL = 28;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  irl_i = 4'hF;
  logic        nmi_i = 1'b0, dbg_irq_i = 1'b0, gen_exc_i = 1'b0, rte_i = 1'b0, vbr_we_i = 1'b0;
  logic [11:0] exc_code_i = '0;
  logic [31:0] pc_i = '0, sr_i = '0, vbr_d_i = '0;
  logic        redirect_o, cpu_rst_o;
  logic [31:0] target_o, sr_o, spc_o, ssr_o;
  logic [11:0] evt_o;

  always #2.5 clk_i = ~clk_i;

  exc_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irl_i(irl_i), .nmi_i(nmi_i), .dbg_irq_i(dbg_irq_i),
    .gen_exc_i(gen_exc_i), .exc_code_i(exc_code_i), .rte_i(rte_i), .pc_i(pc_i), .sr_i(sr_i),
    .vbr_we_i(vbr_we_i), .vbr_d_i(vbr_d_i), .redirect_o(redirect_o), .target_o(target_o),
    .sr_o(sr_o), .cpu_rst_o(cpu_rst_o), .spc_o(spc_o), .ssr_o(ssr_o), .evt_o(evt_o)
  );

  typedef struct {
    bit          valid;
    bit          rst;
    logic [31:0] tgt, sr, spc, ssr;
    logic [11:0] evt;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] sr_next = 32'h0000_00F0, sr_drv, spc_m = 0, ssr_m = 0, vbr_m = 0, pc_ctr = 32'h0000_1000;
  logic [11:0] evt_m = 0;
  bit          nmi_m = 0, redir_prev = 0, w_vbr = 0;
  logic [31:0] w_vbr_d = 0;

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus plus its predicted outcome
  task automatic cyc(input bit g, input bit r, input bit n, input bit d, input logic [3:0] l,
                     input logic [11:0] ec, input string tag);
    item_t it;
    bit np, blk;
    logic [31:0] vbr_old;
    @(negedge clk_i);
    sr_drv = sr_next;
    sr_i = sr_drv; gen_exc_i = g; rte_i = r; nmi_i = n; dbg_irq_i = d; irl_i = l;
    exc_code_i = ec; pc_i = pc_ctr; vbr_we_i = w_vbr; vbr_d_i = w_vbr_d;
    it.valid = 0; it.rst = 0; it.tgt = 0; it.sr = 0; it.tag = tag;
    np = nmi_m | n;
    blk = sr_drv[BL] | redir_prev;
    vbr_old = vbr_m;
    if (w_vbr) vbr_m = w_vbr_d;
    if (g && blk) begin
      it.valid = 1; it.rst = 1; it.tgt = 32'hA000_0000; it.sr = 32'h7000_00F0;
      evt_m = 0; vbr_m = 0;
    end else if (g) begin
      it.valid = 1; it.tgt = vbr_old + 32'h100; it.sr = sr_drv | (32'd1 << BL);
      spc_m = pc_ctr; ssr_m = sr_drv; evt_m = ec;
    end else if (r) begin
      it.valid = 1; it.tgt = spc_m; it.sr = ssr_m;
    end else if (!blk && (np || d || l != 4'hF)) begin
      it.valid = 1; it.tgt = vbr_old + 32'h600; it.sr = sr_drv | (32'd1 << BL);
      spc_m = pc_ctr; ssr_m = sr_drv;
      if (np) begin evt_m = 12'h1C0; np = 0; end
      else if (d) evt_m = 12'h5E0;
      else evt_m = 12'h200 + {3'b0, l, 5'b0};
    end
    nmi_m = np;
    it.spc = spc_m; it.ssr = ssr_m; it.evt = evt_m;
    q.push_back(it);
    redir_prev = it.valid;
    if (it.valid) sr_next = it.sr;
    pc_ctr = pc_ctr + 4;
    w_vbr = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 4'hF, 12'h0, tag);
  endtask

  task automatic clr_bl();
    sr_next[BL] = 1'b0;
  endtask

  // monitor: compares each cycle's outputs against the popped prediction
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(redirect_o == it.valid, it.tag, "redirect", {31'b0, redirect_o}, {31'b0, it.valid});
      if (it.valid) begin
        chk(target_o == it.tgt, it.tag, "target", target_o, it.tgt);
        chk(sr_o == it.sr, it.tag, "sr", sr_o, it.sr);
        chk(cpu_rst_o == it.rst, it.tag, "cpu_rst", {31'b0, cpu_rst_o}, {31'b0, it.rst});
      end
      chk(spc_o == it.spc, it.tag, "spc", spc_o, it.spc);
      chk(ssr_o == it.ssr, it.tag, "ssr", ssr_o, it.ssr);
      chk(evt_o == it.evt, it.tag, "evt", {20'b0, evt_o}, {20'b0, it.evt});
      // R2: reserved codes never appear
      chk(evt_o != 12'h120 && evt_o != 12'h140 && evt_o != 12'h3E0, "R2", "reserved evt",
          {20'b0, evt_o}, 32'h0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R10 reset state
    chk(redirect_o == 0 && cpu_rst_o == 0, "R10", "reset redirect", {31'b0, redirect_o}, 32'h0);
    chk(target_o == 0 && sr_o == 0, "R10", "reset target", target_o, 32'h0);
    chk(spc_o == 0 && ssr_o == 0 && evt_o == 0, "R10", "reset saved", spc_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2, "R10");

    // R3 general exception, vector base 0 after reset
    cyc(1, 0, 0, 0, 4'hF, 12'h0E0, "R3");
    idle(2, "R5");
    // R8 return, not masked by block bit
    cyc(0, 1, 0, 0, 4'hF, 12'h0, "R8");
    idle(1, "R8");

    // R10 vector base write
    w_vbr = 1; w_vbr_d = 32'h8C00_0000;
    idle(1, "R10");

    // R1 all levels, each followed by a return
    for (int n = 0; n < 15; n++) begin
      cyc(0, 0, 0, 0, 4'(n), 12'h0, "R1");
      cyc(0, 1, 0, 0, 4'hF, 12'h0, "R8");
      idle(1, "R1");
    end
    cyc(0, 0, 0, 0, 4'hF, 12'h0, "R1");

    // R4 nmi beats debug beats level
    cyc(0, 0, 1, 1, 4'h3, 12'h0, "R4");
    // R5 debug held while blocked
    cyc(0, 0, 0, 1, 4'hF, 12'h0, "R5");
    cyc(0, 0, 0, 1, 4'hF, 12'h0, "R5");
    cyc(0, 0, 0, 1, 4'h5, 12'h0, "R5");
    clr_bl();
    cyc(0, 0, 0, 1, 4'h5, 12'h0, "R5");
    cyc(0, 0, 0, 0, 4'h5, 12'h0, "R5");
    cyc(0, 0, 0, 0, 4'h5, 12'h0, "R5");
    // R4 return beats level; level taken next
    cyc(0, 1, 0, 0, 4'h5, 12'h0, "R4");
    cyc(0, 0, 0, 0, 4'h5, 12'h0, "R4");
    cyc(0, 0, 0, 0, 4'h5, 12'h0, "R4");
    cyc(0, 1, 0, 0, 4'hF, 12'h0, "R8");
    idle(1, "R8");

    // R6 nmi pulse while blocked
    cyc(0, 0, 0, 0, 4'hA, 12'h0, "R6");
    idle(1, "R6");
    cyc(0, 0, 1, 0, 4'hF, 12'h0, "R6");
    idle(3, "R6");
    clr_bl();
    idle(2, "R6");
    clr_bl();
    idle(3, "R6");

    // R4 general exception beats nmi in the same cycle
    cyc(1, 0, 1, 0, 4'h2, 12'h160, "R4");
    clr_bl();
    idle(3, "R6");

    // R9 nesting overwrites saved registers
    clr_bl();
    idle(1, "R9");
    cyc(0, 0, 0, 0, 4'h7, 12'h0, "R9");
    clr_bl();
    idle(1, "R9");
    cyc(0, 0, 0, 0, 4'h9, 12'h0, "R9");
    cyc(0, 1, 0, 0, 4'hF, 12'h0, "R9");
    idle(1, "R9");

    // R7 general exception while blocked
    clr_bl();
    idle(1, "R7");
    cyc(0, 0, 0, 0, 4'h2, 12'h0, "R7");
    idle(1, "R7");
    cyc(1, 0, 0, 0, 4'hF, 12'h0A0, "R7");
    idle(2, "R7");
    clr_bl();
    cyc(0, 0, 0, 0, 4'h4, 12'h0, "R7");
    idle(3, "R7");

    while (q.size() > 0) @(posedge clk_i);
    @(posedge clk_i); #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule